// File: doc/BRIEF.md
# Sub-word Load/Store Lane Aligner

This block sits between a load/store execution unit and a row-wide data memory, which it holds internally. A request carries a byte address, an access size of 1, 2, 4 or 8 bytes, a byte-reversal flag and, for stores, write data. The address is split into a row number and a byte offset inside that row. A load pulls the addressed bytes out of the row and returns them right-justified and zero-extended. A store reads the old row, clears the addressed lane, inserts the new bytes and writes the row back. When the reversal flag is set, the bytes are reversed within the access size, not over the whole row.

A request whose offset is not a multiple of its size is rejected. The block returns an alignment flag and does not touch memory. Requests use a valid/ready handshake. Each accepted request produces one response pulse.

Control is a two-state machine:
- `ST_IDLE` accepts requests. Loads and rejected requests answer from this state.
- An accepted aligned store moves the machine to `ST_WRITE`. That state writes the merged row and always returns to `ST_IDLE` on the next edge.

Top module: `subword_lane_unit`

## Requirements
- R1: The row number is the address divided by ROW_BYTES (default 8), and the byte offset is the address modulo ROW_BYTES. Size code 0, 1, 2 and 3 selects 1, 2, 4 and 8 bytes.
- R2: If the offset is not a multiple of the access size, the response has `rsp_misalign`=1 and `rsp_rdata`=0. Memory is left unchanged and `req_ready` stays high.
- R3: A load returns byte i of the access in `rsp_rdata` bits [8i+7:8i], taken from row byte offset+i. All bits above the access size are zero.
- R4: An aligned store replaces only the bytes offset to offset+size-1 of the addressed row. Every other byte of that row keeps its value, and store-data bytes above the access size are ignored.
- R5: A size-3 (8-byte) access moves the whole row with no shift.
- R6: With `req_swap`=1, a load returns the extracted bytes in reverse order within the access size.
- R7: With `req_swap`=1, a store reverses the low size bytes of its data before inserting them, so data byte 0 lands at row byte offset+size-1.
- R8: After reset, `rsp_valid` is 0, `req_ready` is 1, and a load from any row that has never been written returns zero.
- R9: An accepted aligned store lowers `req_ready` for exactly one cycle. It responds with `rsp_valid`=1 and `rsp_rdata`=0 two cycles after acceptance.
- R10: A load, or any rejected request, responds with a one-cycle `rsp_valid` pulse in the cycle after acceptance, and `req_ready` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset; also clears the memory |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W (7) | Byte address |
| req_size | input | 2 | Access size code, 2^code bytes |
| req_swap | input | 1 | Reverse bytes within the access size |
| req_wdata | input | DATA_W (64) | Store data, right-justified |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_misalign | output | 1 | Response belongs to a rejected, misaligned request |
| rsp_rdata | output | DATA_W (64) | Load result; zero for stores and rejected requests |

## Verification
The handshake assertions assume that requests are counted only when `req_valid` and `req_ready` are both high. They also assume the source holds nothing across the store stall, because the block samples a new request only when it is ready.

The stimulus drives one request at a time and drops `req_valid` right after acceptance, which keeps acceptance edges isolated. Random addresses cover every offset. Random sizes and swap flags deliberately include misaligned combinations, and store data is fully random above the access size. A full-row read-back after every store checks the untouched bytes against a byte-level reference model.

// File: rtl/sw_lane_pkg.sv
package sw_lane_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_WRITE = 1'b1
    } sw_state_e;
endpackage

// File: rtl/sw_lane_decode.sv
module sw_lane_decode #(
    parameter int ROW_BYTES = 8,
    parameter int ROWS      = 16,
    localparam int OFF_W    = $clog2(ROW_BYTES),
    localparam int ROW_W    = $clog2(ROWS),
    localparam int ADDR_W   = ROW_W + OFF_W,
    localparam int DATA_W   = 8 * ROW_BYTES,
    localparam int SHIFT_W  = OFF_W + 3
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [1:0]         size,
    output logic [ROW_W-1:0]   row_idx,
    output logic [SHIFT_W-1:0] lane_shift,
    output logic [DATA_W-1:0]  lane_mask,
    output logic               full_row,
    output logic               misalign
);
    logic [OFF_W-1:0] offset;
    logic [OFF_W:0]   nbytes;

    assign offset     = addr[OFF_W-1:0];
    assign row_idx    = addr[ADDR_W-1:OFF_W];
    assign nbytes     = (OFF_W+1)'(1) << size;
    assign misalign   = |({1'b0, offset} & (nbytes - (OFF_W+1)'(1)));
    assign full_row   = (nbytes == (OFF_W+1)'(ROW_BYTES));
    assign lane_shift = {offset, 3'b000};

    for (genvar i = 0; i < ROW_BYTES; i++) begin : g_mask
        assign lane_mask[8*i +: 8] = ((OFF_W+1)'(i) < nbytes) ? 8'hFF : 8'h00;
    end
endmodule

// File: rtl/sw_lane_swap.sv
module sw_lane_swap #(
    parameter int ROW_BYTES = 8,
    localparam int DATA_W   = 8 * ROW_BYTES
) (
    input  logic              en,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    always_comb begin
        dout = din;
        if (en) begin
            dout = '0;
            for (int i = 0; i < ROW_BYTES; i++) begin
                if (i < (1 << size)) begin
                    dout[8*i +: 8] = din[8*((1 << size) - 1 - i) +: 8];
                end
            end
        end
    end
endmodule

// File: rtl/subword_lane_unit.sv
module subword_lane_unit
    import sw_lane_pkg::*;
#(
    parameter int ROW_BYTES = 8,
    parameter int ROWS      = 16,
    localparam int OFF_W    = $clog2(ROW_BYTES),
    localparam int ROW_W    = $clog2(ROWS),
    localparam int ADDR_W   = ROW_W + OFF_W,
    localparam int DATA_W   = 8 * ROW_BYTES,
    localparam int SHIFT_W  = OFF_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_swap,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_misalign,
    output logic [DATA_W-1:0] rsp_rdata
);
    sw_state_e state_q, state_d;

    logic [DATA_W-1:0]  mem [ROWS];
    logic [ROW_W-1:0]   dec_row;
    logic [SHIFT_W-1:0] dec_shift;
    logic [DATA_W-1:0]  dec_mask;
    logic               dec_full, dec_misalign;
    logic               accept;
    logic [DATA_W-1:0]  row_rd, ld_raw, ld_data, st_masked, st_lane;

    logic [ROW_W-1:0]   hold_row;
    logic [DATA_W-1:0]  hold_old, hold_lane, hold_clear;
    logic               hold_full;
    logic [DATA_W-1:0]  merged;

    sw_lane_decode #(.ROW_BYTES(ROW_BYTES), .ROWS(ROWS)) u_decode (
        .addr       (req_addr),
        .size       (req_size),
        .row_idx    (dec_row),
        .lane_shift (dec_shift),
        .lane_mask  (dec_mask),
        .full_row   (dec_full),
        .misalign   (dec_misalign)
    );

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign row_rd    = mem[dec_row];

    // load: extract lane (full row bypasses shift/mask), then optional reversal
    assign ld_raw = dec_full ? row_rd : ((row_rd >> dec_shift) & dec_mask);

    sw_lane_swap #(.ROW_BYTES(ROW_BYTES)) u_ld_swap (
        .en(req_swap), .size(req_size), .din(ld_raw), .dout(ld_data)
    );

    // store: trim data to the access size, reverse if asked, before merging
    assign st_masked = req_wdata & dec_mask;

    sw_lane_swap #(.ROW_BYTES(ROW_BYTES)) u_st_swap (
        .en(req_swap), .size(req_size), .din(st_masked), .dout(st_lane)
    );

    assign merged = hold_full ? hold_lane : ((hold_old & ~hold_clear) | hold_lane);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept && req_write && !dec_misalign) state_d = ST_WRITE;
            ST_WRITE: state_d = ST_IDLE;
        endcase
    end

    // outputs and store capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_misalign <= 1'b0;
            rsp_rdata    <= '0;
            hold_row     <= '0;
            hold_old     <= '0;
            hold_lane    <= '0;
            hold_clear   <= '0;
            hold_full    <= 1'b0;
        end else begin
            rsp_valid    <= 1'b0;
            rsp_misalign <= 1'b0;
            rsp_rdata    <= '0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (dec_misalign) begin
                            rsp_valid    <= 1'b1;
                            rsp_misalign <= 1'b1;
                        end else if (!req_write) begin
                            rsp_valid <= 1'b1;
                            rsp_rdata <= ld_data;
                        end else begin
                            hold_row   <= dec_row;
                            hold_old   <= row_rd;
                            hold_lane  <= st_lane << dec_shift;
                            hold_clear <= dec_mask << dec_shift;
                            hold_full  <= dec_full;
                        end
                    end
                end
                ST_WRITE: rsp_valid <= 1'b1;
            endcase
        end
    end

    // row storage, cleared by reset so unwritten rows read zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) mem[r] <= '0;
        end else if (state_q == ST_WRITE) begin
            mem[hold_row] <= merged;
        end
    end
endmodule

// File: rtl/sw_lane_checker.sv
module sw_lane_checker #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [1:0]        req_size,
    input logic              rsp_valid,
    input logic              rsp_misalign,
    input logic [DATA_W-1:0] rsp_rdata
);
    // R2: an alignment flag only ever rides on a response and carries no data
    p_flag_with_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_misalign |-> (rsp_valid && rsp_rdata == '0));

    // R10: a load answers in the next cycle without stalling
    p_load_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write) |=> (rsp_valid && req_ready));

    // R9: a store either stalls (aligned) or is rejected at once
    p_store_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write) |=> (!req_ready || rsp_misalign));

    // R9: the stall lasts one cycle and ends with the response
    p_store_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready) |=> (req_ready && rsp_valid && rsp_rdata == '0));

    // R3: single-byte loads are zero-extended
    p_zero_ext_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write && req_size == 2'd0)
            |=> (rsp_rdata[DATA_W-1:8] == '0));

    // R8: out of reset the block is ready and silent
    p_reset_state_r8: assert property (@(posedge clk)
        $rose(rst_n) |-> (req_ready && !rsp_valid));
endmodule

bind subword_lane_unit sw_lane_checker #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_write    (req_write),
    .req_size     (req_size),
    .rsp_valid    (rsp_valid),
    .rsp_misalign (rsp_misalign),
    .rsp_rdata    (rsp_rdata)
);

// File: tb/subword_lane_unit_bench.sv
module subword_lane_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ROW_BYTES  = 8;
    localparam int ROWS       = 16;
    localparam int ADDR_W     = 7;
    localparam int DATA_W     = 64;
    localparam int MAX_CYCLES = 100000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [1:0]        req_size = '0;
    logic              req_swap = 1'b0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              rsp_valid;
    logic              rsp_misalign;
    logic [DATA_W-1:0] rsp_rdata;

    int unsigned n_tests = 0;
    int unsigned n_fail  = 0;
    bit          done    = 1'b0;
    logic [DATA_W-1:0] model [ROWS];

    always #(CLK_PERIOD/2) clk = ~clk;

    subword_lane_unit #(.ROW_BYTES(ROW_BYTES), .ROWS(ROWS)) u_subword_lane_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
        .req_swap(req_swap), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_misalign(rsp_misalign), .rsp_rdata(rsp_rdata)
    );

    function automatic logic [DATA_W-1:0] ref_load(logic [DATA_W-1:0] row, int off, int nb, bit sw);
        logic [DATA_W-1:0] r = '0;
        for (int i = 0; i < nb; i++) begin
            r[8*(sw ? nb-1-i : i) +: 8] = row[8*(off+i) +: 8];
        end
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] ref_store(logic [DATA_W-1:0] row, int off, int nb, bit sw,
                                                    logic [DATA_W-1:0] d);
        logic [DATA_W-1:0] r = row;
        for (int i = 0; i < nb; i++) begin
            r[8*(off+i) +: 8] = d[8*(sw ? nb-1-i : i) +: 8];
        end
        return r;
    endfunction

    task automatic check(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(bit wr, int addr, int sz, bit sw, logic [DATA_W-1:0] wd, string tag);
        int nb  = 1 << sz;
        int off = addr % ROW_BYTES;
        int row = addr / ROW_BYTES;
        bit mis = (off % nb) != 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = ADDR_W'(addr);
        req_size = 2'(sz); req_swap = sw; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        if (mis) begin
            check({tag, " R2 valid"}, {63'd0, rsp_valid}, 64'd1);
            check({tag, " R2 flag"}, {63'd0, rsp_misalign}, 64'd1);
            check({tag, " R2 data"}, rsp_rdata, '0);
            check({tag, " R2 ready"}, {63'd0, req_ready}, 64'd1);
        end else if (!wr) begin
            check({tag, " R10 valid"}, {62'd0, rsp_valid, req_ready}, 64'd3);
            check({tag, " R3 load"}, rsp_rdata, ref_load(model[row], off, nb, sw));
        end else begin
            check({tag, " R9 stall"}, {62'd0, req_ready, rsp_valid}, 64'd0);
            model[row] = ref_store(model[row], off, nb, sw, wd);
            @(negedge clk);
            check({tag, " R9 done"}, {61'd0, req_ready, rsp_valid, rsp_misalign}, 64'd6);
            check({tag, " R9 data"}, rsp_rdata, '0);
        end
    endtask

    // full-row read-back of one row (R4 untouched bytes, R5 whole row)
    task automatic readback(int row, string tag);
        run_op(1'b0, row * ROW_BYTES, 3, 1'b0, '0, {tag, " R4 R5 readback"});
    endtask

    initial begin : watchdog
        repeat (MAX_CYCLES) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        int unsigned seed_val;
        seed_val = $urandom(32'd4242);
        for (int r = 0; r < ROWS; r++) model[r] = '0;
        repeat (3) @(negedge clk);
        check("R8 reset ready/valid", {62'd0, req_ready, rsp_valid}, 64'd2);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 after reset", {62'd0, req_ready, rsp_valid}, 64'd2);

        // directed corners
        run_op(1'b0, 15*8, 3, 1'b0, '0, "R8 unwritten row");
        run_op(1'b0, 9*8+4, 2, 1'b1, '0, "R8 unwritten word");
        run_op(1'b1, 2*8, 3, 1'b0, 64'h8877665544332211, "R5 full store");
        readback(2, "R5");
        run_op(1'b1, 2*8+7, 0, 1'b0, 64'hFFFF_FFFF_FFFF_FFAB, "R4 top byte");
        readback(2, "R4");
        run_op(1'b1, 2*8+1, 1, 1'b0, 64'h0000_0000_0000_DEAD, "R2 misaligned store");
        readback(2, "R2 unchanged");
        run_op(1'b0, 2*8+2, 2, 1'b0, '0, "R2 misaligned load");
        run_op(1'b0, 2*8+4, 2, 1'b1, '0, "R6 swapped word load");
        run_op(1'b0, 2*8+2, 1, 1'b0, '0, "R1 halfword offset 2");
        run_op(1'b1, 3*8+4, 2, 1'b1, 64'h1234_5678_A1B2_C3D4, "R7 swapped word store");
        readback(3, "R7");
        run_op(1'b1, 4*8, 3, 1'b1, 64'h0102030405060708, "R7 R5 swapped full store");
        readback(4, "R7 R5");
        run_op(1'b0, 4*8, 3, 1'b1, '0, "R6 R5 swapped full load");

        // constrained random mix
        for (int k = 0; k < 600; k++) begin
            bit wr  = ($urandom % 2) == 1;
            int adr = int'($urandom % (ROWS * ROW_BYTES));
            int sz  = int'($urandom % 4);
            bit sw  = ($urandom % 3) == 0;
            logic [DATA_W-1:0] wd = {$urandom, $urandom};
            run_op(wr, adr, sz, sw, wd, wr ? "R4 R7 rand store" : "R3 R6 rand load");
            if (wr) readback(adr / ROW_BYTES, "R4 rand");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule